// File: doc/BRIEF.md
# Two-Group Serial Command Port with Channel-Enable Broadcast

This block is the host-facing control port of a voice front end that holds eight channels, arranged as two groups of four. A host shifts in a command byte followed by one data byte on a shared serial line. Each group answers to its own active-low chip select. Each group keeps a four-bit enable mask, with one bit per channel. A parameter write lands in every channel whose enable bit is set, in every group whose chip select is low. Lowering both chip selects with all bits set therefore broadcasts one write to all eight channels.

Reads shift one byte back out, most significant bit first. When several channels qualify for a parameter read, the lowest-numbered one answers. Each channel owns a small byte-wide register file. A side port lets any channel register be observed directly. The block's serial inputs are sampled by the system clock, and a serial-clock rising edge is recognised when the sampled value goes from 0 to 1.

Top module: `chan_cmd_port`

## Requirements
- R1: After reset, every enable bit and every channel register reads zero, and `sdo` is low.
- R2: Command 0x4A stores the low four bits of the data byte as the enable mask of each group whose chip select is low. Command 0x4B returns the mask of the selected group, zero-extended to eight bits. If both chip selects are low, command 0x4B returns the mask of group 0.
- R3: Command `0x10 | (a<<1)` with a < 4 writes the data byte to register a of every channel whose enable bit is set and whose group chip select is low. No other channel changes.
- R4: With both chip selects low and both masks at 0xF, a single parameter write updates register a of all eight channels. Group 0 holds channels 0 to 3, and group 1 holds channels 4 to 7.
- R5: Command `0x11 | (a<<1)` returns register a of the lowest-numbered enabled channel among the selected groups. If no channel qualifies, it returns 0x00.
- R6: A transfer changes state only on the sixteenth serial-clock rise, and only while a chip select is still low at that sample. If both chip selects go high before that sample, or in the same sample, the transfer is dropped.
- R7: A command byte that is neither 0x4A nor a parameter command with a < 4 changes no register. Its read-back is 0x00.
- R8: Bits are taken MSB first on each serial-clock rise. On a read, bit 7 of the reply is on `sdo` after the command byte, and each later rise advances `sdo` by one bit. `sdo` is low while a command byte is being shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset shared by both groups |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 2 | Active-low chip selects; bit g selects group g |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data to the host |
| insp_ch | input | 3 | Channel index for the observation port |
| insp_addr | input | 2 | Register index for the observation port |
| insp_data | output | 8 | Contents of the observed channel register |

## Verification
The write commit on the final data rise can fall in the same system-clock sample as the release of both chip selects. The bench provokes this by raising `sck` and both chip selects together on the sixteenth bit. It judges the result by comparing every channel register against its model on each clock, and then by reading the enable mask back. An abort part-way through the command byte and another part-way through the data byte are judged the same way. The bench also exercises a broadcast write across both groups directly before a read, so the register update and the lowest-channel selection are observed one after the other.

// File: rtl/chan_cmd_port.sv
module chan_cmd_port #(
  parameter int CPG  = 4,
  parameter int NREG = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sck,
  input  logic [1:0]                    cs_n,
  input  logic                          sdi,
  output logic                          sdo,
  input  logic [$clog2(2*CPG)-1:0]      insp_ch,
  input  logic [$clog2(NREG)-1:0]       insp_addr,
  output logic [7:0]                    insp_data
);
  localparam int NCH = 2 * CPG;
  localparam int AW  = $clog2(NREG);
  localparam logic [7:0] CMD_EN_WR = 8'h4A;
  localparam logic [7:0] CMD_EN_RD = 8'h4B;

  logic                    sck_q;
  logic [3:0]              cnt;
  logic [7:0]              shreg, cmd, obuf, rd_val;
  logic [1:0][CPG-1:0]     en;
  logic [7:0]              rf [NCH][NREG];

  wire             any_sel = ~&cs_n;
  wire             rise    = sck & ~sck_q;
  wire [7:0]       byte_in = {shreg[6:0], sdi};
  wire             last    = rise && any_sel && cnt == 4'd15;
  wire [NCH-1:0]   hit     = en & {{CPG{~cs_n[1]}}, {CPG{~cs_n[0]}}};
  wire             in_par  = byte_in[7:4] == 4'h1 && int'(byte_in[3:1]) < NREG;
  wire             cmd_par = cmd[7:4] == 4'h1 && int'(cmd[3:1]) < NREG;
  wire [AW-1:0]    in_addr  = byte_in[1 +: AW];
  wire [AW-1:0]    cmd_addr = cmd[1 +: AW];

  assign sdo       = obuf[7];
  assign insp_data = rf[insp_ch][insp_addr];

  always_comb begin
    rd_val = '0;
    if (byte_in == CMD_EN_RD) begin
      if (!cs_n[1]) rd_val = 8'(en[1]);
      if (!cs_n[0]) rd_val = 8'(en[0]);
    end else if (in_par && byte_in[0]) begin
      for (int i = NCH - 1; i >= 0; i--)
        if (hit[i]) rd_val = rf[i][in_addr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cnt   <= '0;
      shreg <= '0;
      cmd   <= '0;
      obuf  <= '0;
    end else begin
      sck_q <= sck;
      if (!any_sel) begin
        cnt  <= '0;
        obuf <= '0;
      end else if (rise) begin
        cnt   <= cnt + 4'd1;
        shreg <= byte_in;
        if (cnt == 4'd7) begin
          cmd  <= byte_in;
          obuf <= rd_val;
        end else begin
          obuf <= {obuf[6:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= '0;
      for (int i = 0; i < NCH; i++)
        for (int j = 0; j < NREG; j++)
          rf[i][j] <= '0;
    end else if (last) begin
      if (cmd == CMD_EN_WR) begin
        for (int g = 0; g < 2; g++)
          if (!cs_n[g]) en[g] <= byte_in[CPG-1:0];
      end else if (cmd_par && !cmd[0]) begin
        for (int i = 0; i < NCH; i++)
          if (hit[i]) rf[i][cmd_addr] <= byte_in;
      end
    end
  end

  assert_enable_only_at_frame_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(en) |-> $past(rise && any_sel && cnt == 4'd15));

  assert_enable_only_by_mask_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(en) |-> $past(cmd) == CMD_EN_WR);

  assert_one_bit_per_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && any_sel && cnt != 4'd15) |=> cnt == $past(cnt) + 4'd1);

  assert_sdo_quiet_in_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt < 4'd8) |-> !sdo);

  assert_deselect_clears_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n) |=> cnt == 4'd0);
endmodule

// File: tb/chan_cmd_port_tb.sv
module chan_cmd_port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic [1:0] cs_n = 2'b11;
  logic       sdo;
  logic [2:0] insp_ch = '0;
  logic [1:0] insp_addr = '0;
  logic [7:0] insp_data;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [3:0] en_m [2];
  logic [7:0] rf_m [8][4];
  logic [4:0] idx = '0;

  chan_cmd_port dut_i (.clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .sdi(sdi),
    .sdo(sdo), .insp_ch(insp_ch), .insp_addr(insp_addr), .insp_data(insp_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // every clock: the observed channel register against the model (R1/R3/R4/R6/R7)
  always @(negedge clk) if (rst_n && !done) begin
    check("R1/R3/R4/R6/R7 channel register", insp_data, rf_m[insp_ch][insp_addr]);
    idx = idx + 5'd1;
    insp_ch = idx[4:2];
    insp_addr = idx[1:0];
  end

  function automatic logic [7:0] model_read(input logic [1:0] c, input logic [7:0] cmd);
    if (cmd == 8'h4B) begin
      if (!c[0]) return {4'h0, en_m[0]};
      if (!c[1]) return {4'h0, en_m[1]};
    end else if (cmd[7:4] == 4'h1 && cmd[0] && cmd[3] == 1'b0) begin
      for (int i = 0; i < 8; i++)
        if (!c[i/4] && en_m[i/4][i%4]) return rf_m[i][cmd[2:1]];
    end
    return 8'h00;
  endfunction

  function automatic void model_apply(input logic [1:0] c, input logic [7:0] cmd, input logic [7:0] d);
    if (cmd == 8'h4A) begin
      for (int g = 0; g < 2; g++) if (!c[g]) en_m[g] = d[3:0];
    end else if (cmd[7:4] == 4'h1 && !cmd[0] && cmd[3] == 1'b0) begin
      for (int i = 0; i < 8; i++)
        if (!c[i/4] && en_m[i/4][i%4]) rf_m[i][cmd[2:1]] = d;
    end
  endfunction

  // abort_at: bit index at which both selects rise first; 100 = rise together with the last sck
  task automatic xfer(input logic [1:0] c, input logic [7:0] cmd, input logic [7:0] d,
                      input int abort_at, input string req);
    logic [7:0] exp = model_read(c, cmd);
    logic [7:0] got = '0;
    @(negedge clk); cs_n = c;
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      if (i == abort_at) begin
        cs_n = 2'b11; sck = 1'b0;
        repeat (3) @(negedge clk);
        return;
      end
      sdi = (i < 8) ? cmd[7-i] : d[15-i];
      sck = 1'b0;
      @(negedge clk); @(negedge clk);
      if (i < 8) check("R8 sdo low during command", {7'd0, sdo}, 8'd0);
      else got[15-i] = sdo;
      sck = 1'b1;
      if (i == 15) begin
        if (abort_at == 100) cs_n = 2'b11;
        @(posedge clk);
        if (abort_at != 100) model_apply(c, cmd, d);
        @(negedge clk);
      end else begin
        @(negedge clk); @(negedge clk);
      end
    end
    sck = 1'b0;
    @(negedge clk); cs_n = 2'b11;
    repeat (2) @(negedge clk);
    if (abort_at < 0) check(req, got, exp);
  endtask

  initial begin
    for (int g = 0; g < 2; g++) en_m[g] = '0;
    for (int i = 0; i < 8; i++) for (int j = 0; j < 4; j++) rf_m[i][j] = '0;
    repeat (3) @(negedge clk);
    check("R1 sdo in reset", {7'd0, sdo}, 8'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    xfer(2'b10, 8'h4B, 8'h00, -1, "R1 mask after reset");
    xfer(2'b10, 8'h13, 8'h00, -1, "R1 register after reset");
    xfer(2'b10, 8'h4A, 8'hFF, -1, "R2 write mask");
    xfer(2'b10, 8'h4B, 8'h00, -1, "R2 mask upper bits zero");
    xfer(2'b10, 8'h4A, 8'h05, -1, "R2 write mask");
    xfer(2'b10, 8'h4B, 8'h00, -1, "R2 read mask group0");
    xfer(2'b01, 8'h4B, 8'h00, -1, "R2 group1 untouched");
    xfer(2'b10, 8'h12, 8'hA5, -1, "R3 fan-out write");
    xfer(2'b10, 8'h13, 8'h00, -1, "R5 read lowest enabled");
    xfer(2'b01, 8'h13, 8'h00, -1, "R3 group1 not written");
    xfer(2'b00, 8'h4A, 8'h0F, -1, "R4 mask both groups");
    xfer(2'b00, 8'h4B, 8'h00, -1, "R2 both selects read group0");
    xfer(2'b00, 8'h16, 8'h3C, -1, "R4 broadcast write");
    xfer(2'b01, 8'h17, 8'h00, -1, "R4 broadcast reached group1");
    xfer(2'b10, 8'h4A, 8'h04, -1, "R5 mask ch2");
    xfer(2'b10, 8'h10, 8'h11, -1, "R5 write ch2");
    xfer(2'b10, 8'h4A, 8'h08, -1, "R5 mask ch3");
    xfer(2'b10, 8'h10, 8'h77, -1, "R5 write ch3");
    xfer(2'b10, 8'h4A, 8'h0C, -1, "R5 mask ch2 and ch3");
    xfer(2'b10, 8'h11, 8'h00, -1, "R5 lowest of ch2/ch3");
    xfer(2'b00, 8'h11, 8'h00, -1, "R5 lowest across groups");
    xfer(2'b10, 8'h4A, 8'h00, -1, "R5 mask none");
    xfer(2'b10, 8'h11, 8'h00, -1, "R5 nothing enabled reads zero");
    xfer(2'b00, 8'h4A, 8'h0F, 5, "R6 abort in command byte");
    xfer(2'b00, 8'h4A, 8'h0F, 12, "R6 abort in data byte");
    xfer(2'b00, 8'h4A, 8'h0F, 100, "R6 abort on last rise");
    xfer(2'b10, 8'h4B, 8'h00, -1, "R6 mask unchanged after aborts");
    xfer(2'b01, 8'h4B, 8'h00, -1, "R6 group1 mask unchanged");
    xfer(2'b00, 8'h18, 8'hEE, -1, "R7 out-of-range register");
    xfer(2'b00, 8'h20, 8'hEE, -1, "R7 unknown command");
    xfer(2'b00, 8'h19, 8'h00, -1, "R7 out-of-range read zero");
    xfer(2'b01, 8'h17, 8'h00, -1, "R7 ch4 register intact");
    repeat (40) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule